// File: doc/BRIEF.md
# Preset RAM with Restore-on-Reset Sequencer

This block is a single-port synchronous RAM that wakes up already holding a fixed table of preset words, so no cycles are spent loading it after power-up. Next to the working array sits an unchanging copy of the preset table, computed from the address. User writes only ever modify the working array.

When the synchronous reset is asserted at run time, a sequencer copies the preset table back into the working array. It writes one address per clock, starting from address 0, so a depth of N costs N cycles. While the copy runs, `busy` is high and user reads and writes are refused. A parameter per instance turns this restore off. In that case reset leaves the contents alone and only the power-up values apply. Once `busy` is low, the block is an ordinary read-first RAM with one cycle of read latency.

Top module: `ram_preset_restore`

## Requirements
- R1: At power-up, before any reset, `busy` is 0 and the words at addresses 0 to 7 read as the 16-bit two's complement values -2, 8, -4, 10, 14, 10, -4, 8. Deeper instances repeat this pattern of eight.
- R2: With RESTORE_EN=1, a clock edge with `rst` high sets `busy` to 1 and clears `rdata` to 0.
- R3: After `rst` falls, the restore writes addresses 0 through DEPTH-1, one per clock. `busy` stays high for exactly DEPTH clock edges, and afterwards every word equals its preset value.
- R4: Asserting `rst` again during a restore restarts the walk at address 0. `busy` then stays high for DEPTH edges counted from the new release.
- R5: A read requested while `busy` is high is ignored, and `rdata` keeps its previous value.
- R6: A write requested while `busy` is high is dropped and never reaches the working array.
- R7: With RESTORE_EN=0, `rst` only clears `rdata` to 0. `busy` stays 0 and the stored words are unchanged.
- R8: When not busy, `en`=1 returns the addressed word on `rdata` one edge later. A write with `en`=1 and `we`=1 returns the old word (read-first) and stores `wdata`. With `en`=0, `rdata` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous run-time reset, active high |
| en | input | 1 | Access request |
| we | input | 1 | Write select, qualified by `en` |
| addr | input | AW | Word address, AW = clog2(DEPTH) |
| wdata | input | WIDTH | Write data |
| rdata | output | WIDTH | Registered read data |
| busy | output | 1 | Restore in progress; user access refused |

## Verification
The bench drives two instances, one with the restore enabled and one without, from the same inputs. It compares every cycle against a scoreboard model. A write issued in the last busy cycle to an address that has already been restored catches a design that lets busy writes through, because the value would survive the restore. A second reset in the middle of a restore catches a counter that resumes instead of restarting, since `busy` would then fall early. Reads while busy catch an `rdata` that is not held. Off-by-one restore lengths show up as `busy` falling a cycle too early or too late.

// File: rtl/ram_preset_restore.sv
module ram_preset_restore #(
  parameter int DEPTH      = 8,
  parameter int WIDTH      = 16,
  parameter bit RESTORE_EN = 1'b1,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             we,
  input  logic [AW-1:0]    addr,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] rdata,
  output logic             busy
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  // unchanging preset store: a pattern of eight, computed from the address
  function automatic logic [WIDTH-1:0] preset(int unsigned idx);
    int v;
    case (idx % 8)
      0: v = -2;
      1: v = 8;
      2: v = -4;
      3: v = 10;
      4: v = 14;
      5: v = 10;
      6: v = -4;
      default: v = 8;
    endcase
    return WIDTH'(v);
  endfunction

  logic [WIDTH-1:0] mem [DEPTH];
  logic [WIDTH-1:0] rdata_q = '0;
  logic             busy_q  = 1'b0;
  logic [AW-1:0]    cnt_q   = '0;

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = preset(i);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
      if (RESTORE_EN) begin
        busy_q <= 1'b1;
        cnt_q  <= '0;
      end
    end else if (busy_q) begin
      mem[cnt_q] <= preset(32'(cnt_q));
      cnt_q      <= cnt_q + 1'b1;
      if (cnt_q == LAST) busy_q <= 1'b0;
    end else if (en) begin
      rdata_q <= mem[addr];
      if (we) mem[addr] <= wdata;
    end
  end

  assign rdata = rdata_q;
  assign busy  = busy_q;

  p_busy_ends_at_last_r3: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_q) |-> $past(cnt_q) == LAST);

  p_walk_steps_r4: assert property (@(posedge clk) disable iff (rst)
    (busy_q && $past(busy_q) && !$past(rst)) |-> cnt_q == $past(cnt_q) + 1'b1);

  p_busy_read_hold_r5: assert property (@(posedge clk) disable iff (rst)
    busy_q |=> $stable(rdata_q));

  p_idle_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (!busy_q && !en) |=> $stable(rdata_q));

  p_reset_clears_r2: assert property (@(posedge clk)
    rst |=> rdata_q == '0);

  generate
    if (!RESTORE_EN) begin : g_off
      p_off_never_busy_r7: assert property (@(posedge clk) !busy_q);
    end
  endgenerate
endmodule

// File: tb/ram_preset_restore_tb_top.sv
module ram_preset_restore_tb_top;
  localparam int DEPTH = 8;
  localparam int WIDTH = 16;
  localparam int AW    = 3;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic             rst = 1'b0, en = 1'b0, we = 1'b0;
  logic [AW-1:0]    addr = '0;
  logic [WIDTH-1:0] wdata = '0;
  logic [WIDTH-1:0] rd_on, rd_off;
  logic             bz_on, bz_off;

  ram_preset_restore #(.DEPTH(DEPTH), .WIDTH(WIDTH), .RESTORE_EN(1'b1)) dut_i (
    .clk(clk), .rst(rst), .en(en), .we(we), .addr(addr), .wdata(wdata),
    .rdata(rd_on), .busy(bz_on));
  ram_preset_restore #(.DEPTH(DEPTH), .WIDTH(WIDTH), .RESTORE_EN(1'b0)) dut_off_i (
    .clk(clk), .rst(rst), .en(en), .we(we), .addr(addr), .wdata(wdata),
    .rdata(rd_off), .busy(bz_off));

  typedef struct {
    int               due;
    logic [WIDTH-1:0] exp_rd [2];
    logic             exp_bz [2];
    string            tag;
  } item_t;

  item_t q[$];
  int cyc = 0, compared = 0, mismatched = 0;
  logic [WIDTH-1:0] model_mem [2][DEPTH];
  logic [WIDTH-1:0] model_rd [2];
  int               busy_left [2];

  function automatic logic [WIDTH-1:0] tbl(int i);
    case (i % 8)
      0: return 16'hFFFE;
      1: return 16'h0008;
      2: return 16'hFFFC;
      3: return 16'h000A;
      4: return 16'h000E;
      5: return 16'h000A;
      6: return 16'hFFFC;
      default: return 16'h0008;
    endcase
  endfunction

  always @(posedge clk) cyc <= cyc + 1;

  task automatic step(input logic r, input logic e, input logic w,
                      input int a, input logic [WIDTH-1:0] d, input string tag);
    item_t it;
    @(negedge clk);
    rst = r; en = e; we = w; addr = AW'(a); wdata = d;
    for (int k = 0; k < 2; k++) begin
      if (r) begin
        model_rd[k] = '0;
        if (k == 0) begin
          busy_left[k] = DEPTH;
          for (int j = 0; j < DEPTH; j++) model_mem[k][j] = tbl(j);
        end
      end else if (busy_left[k] > 0) begin
        busy_left[k]--;
      end else if (e) begin
        model_rd[k] = model_mem[k][a];
        if (w) model_mem[k][a] = d;
      end
      it.exp_rd[k] = model_rd[k];
      it.exp_bz[k] = busy_left[k] > 0;
    end
    it.due = cyc + 1;
    it.tag = tag;
    q.push_back(it);
  endtask

  always @(negedge clk) begin
    if (q.size() > 0 && q[0].due == cyc) begin
      item_t it;
      it = q.pop_front();
      for (int k = 0; k < 2; k++) begin
        compared++;
        if ((k == 0 ? rd_on : rd_off) !== it.exp_rd[k]) begin
          mismatched++;
          $display("FAIL %s inst%0d rdata actual %h expected %h", it.tag, k,
                   (k == 0 ? rd_on : rd_off), it.exp_rd[k]);
        end
        compared++;
        if ((k == 0 ? bz_on : bz_off) !== it.exp_bz[k]) begin
          mismatched++;
          $display("FAIL %s inst%0d busy actual %b expected %b", it.tag, k,
                   (k == 0 ? bz_on : bz_off), it.exp_bz[k]);
        end
      end
    end
  end

  initial begin
    for (int k = 0; k < 2; k++) begin
      model_rd[k] = '0;
      busy_left[k] = 0;
      for (int j = 0; j < DEPTH; j++) model_mem[k][j] = tbl(j);
    end
    // R1 power-up contents
    for (int j = 0; j < DEPTH; j++) step(0, 1, 0, j, '0, "R1");
    // R8 read-first write, then readback and hold
    step(0, 1, 1, 3, 16'h1234, "R8");
    step(0, 1, 0, 3, '0, "R8");
    step(0, 0, 0, 0, '0, "R8");
    step(0, 1, 1, 5, 16'hBEEF, "R8");
    // R2 / R7 reset
    step(1, 0, 0, 0, '0, "R2_R7");
    // R5 reads while busy, R6 early busy write
    step(0, 1, 0, 3, '0, "R5");
    step(0, 1, 1, 6, 16'h7777, "R6");
    step(0, 1, 0, 5, '0, "R5");
    // R4 restart mid-restore
    step(1, 0, 0, 0, '0, "R4");
    for (int j = 0; j < DEPTH - 1; j++) step(0, 1, 0, j, '0, "R4");
    // R6 write in final busy cycle to an already restored address
    step(0, 1, 1, 0, 16'hAAAA, "R6");
    // R3 contents after restore
    for (int j = 0; j < DEPTH; j++) step(0, 1, 0, j, '0, "R3");
    step(0, 0, 0, 0, '0, "R8");
    repeat (3) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule